// File: doc/BRIEF.md
# HyperBus Register Write Sequencer

This block performs a single write into the configuration register space of a HyperBus memory device. A local client presents a register address and a 16-bit value and pulses a one-cycle strobe. The sequencer then drives the bus pins directly: chip select, the single-ended bus clock, the 8-bit DQ output and its enable, and RWDS and its enable. On those pins it sends a six-byte command/address word and two data bytes, both at double data rate, and then returns the bus to idle.

Register writes carry no initial latency, so the data bytes follow the command/address word with no gap. RWDS is never driven. Each DQ byte is held for two system clock cycles and the bus clock changes level every two system cycles, so one byte is transferred on each bus clock edge. A busy output tells the client when the sequencer can accept the next strobe.

Top module: `hb_reg_writer`

## Requirements
- R1: After reset the outputs are at their idle levels: cs_n high, bus clock low, DQ 0x00, DQ enable low, busy low.
- R2: A strobe sampled at a clock edge while busy is low drives chip select low after the second following edge. Chip select then stays low for exactly 16 system cycles.
- R3: The first six bytes on DQ form a 48-bit command/address word, sent most significant byte first. Bit 47 is 0 (write), bit 46 is 1 (register space), bit 45 is 1 (linear burst), bits 30:23 hold the register address, and all other bits are 0. For address 2 the bytes are 0x60, 0x00, 0x01, 0x00, 0x00, 0x00.
- R4: The two data bytes follow the sixth header byte with no wait cycles. The low byte goes out first, then the high byte.
- R5: Each DQ byte is held for two consecutive system cycles.
- R6: The bus clock is low in the first cycle with chip select low. After that it changes level every two system cycles, giving exactly four high pulses, and it is low in the last cycle with chip select low and whenever chip select is high.
- R7: The DQ output enable is high in exactly the cycles in which chip select is low.
- R8: RWDS output and RWDS output enable stay low at all times.
- R9: Busy goes high after the edge that accepts a strobe and stays high until chip select is released. Strobes sampled while busy is high are ignored, and the transfer in progress is not changed by them.
- R10: When chip select is released, DQ returns to 0x00 and all pins hold their idle levels until the next strobe. A strobe presented in the first cycle after busy falls is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_stb_i | input | 1 | One-cycle register write request |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | 16 | Register value |
| busy_o | output | 1 | Sequencer occupied |
| hb_cs_n_o | output | 1 | Bus chip select, active low |
| hb_ck_o | output | 1 | Bus clock |
| hb_dq_o | output | 8 | DQ output byte |
| hb_dq_oe_o | output | 1 | DQ output enable |
| hb_rwds_o | output | 1 | RWDS output |
| hb_rwds_oe_o | output | 1 | RWDS output enable |

## Verification
The bench uses the default parameters: an 8-bit register address and two lead cycles between strobe and chip select. With these values the highest address, 0xFF, fills every bit of the address field in the command word, so misplaced or truncated address bits show up on DQ. The two-cycle lead lets the bench place ignored strobes both before chip select falls and during the DQ phase. Back-to-back requests, where a strobe arrives in the very first idle cycle, show that the release and re-accept timing leaves no gap and no overlap.

// File: rtl/hb_reg_pkg.sv
package hb_reg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_XFER = 2'd2
  } seq_state_e;

  localparam int HDR_BYTES  = 6;
  localparam int DATA_BYTES = 2;
  localparam int XFER_BYTES = HDR_BYTES + DATA_BYTES;
  localparam int ADDR_FIELD = 22;   // widest register address the word can carry
  localparam int ADDR_LSB   = 23;   // position of the address field in the word

  // Command/address word for a register-space linear write.
  function automatic logic [47:0] ca_word(input logic [ADDR_FIELD-1:0] reg_addr);
    logic [47:0] w;
    w = '0;
    w[47] = 1'b0;                                  // write
    w[46] = 1'b1;                                  // register space
    w[45] = 1'b1;                                  // linear burst
    w[ADDR_LSB+ADDR_FIELD-1:ADDR_LSB] = reg_addr;
    return w;
  endfunction

  // Bus clock level for transfer cycle k: low first, then two cycles per level.
  function automatic logic bus_ck_level(input logic [7:0] k);
    logic [7:0] n;
    n = k + 8'd1;
    return n[1];
  endfunction

endpackage

// File: rtl/hb_reg_ctrl.sv
module hb_reg_ctrl
  import hb_reg_pkg::*;
#(
  parameter int LEAD_CYCLES = 2,
  parameter int XFER_CYCLES = 16,
  localparam int LEAD_W = (LEAD_CYCLES > 1) ? $clog2(LEAD_CYCLES) : 1,
  localparam int CNT_W  = $clog2(XFER_CYCLES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  output logic             accept_o,
  output logic             in_xfer_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cyc_o
);

  seq_state_e        state_q;
  logic [LEAD_W-1:0] lead_q;
  logic [CNT_W-1:0]  cyc_q;

  assign accept_o  = stb_i && (state_q == ST_IDLE);
  assign in_xfer_o = (state_q == ST_XFER);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = in_xfer_o && (cyc_q == CNT_W'(XFER_CYCLES - 1));
  assign cyc_o     = cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lead_q  <= '0;
      cyc_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            state_q <= ST_LEAD;
            lead_q  <= '0;
          end
        end
        ST_LEAD: begin
          if (lead_q == LEAD_W'(LEAD_CYCLES - 1)) begin
            state_q <= ST_XFER;
            cyc_q   <= '0;
          end else begin
            lead_q <= lead_q + 1'b1;
          end
        end
        ST_XFER: begin
          if (done_o) state_q <= ST_IDLE;
          else        cyc_q   <= cyc_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hb_reg_frame.sv
module hb_reg_frame #(
  parameter int NBYTES = 8,
  localparam int FRAME_W = NBYTES * 8,
  localparam int IDX_W   = $clog2(NBYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [7:0]         byte_o
);

  logic [FRAME_W-1:0] frame_q;
  logic [7:0]         bytes_w [NBYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frame_q <= '0;
    else if (load_i) frame_q <= frame_i;
  end

  // Byte 0 is the most significant byte and leaves the block first.
  for (genvar b = 0; b < NBYTES; b++) begin : g_split
    assign bytes_w[b] = frame_q[FRAME_W-1-8*b -: 8];
  end

  assign byte_o = bytes_w[idx_i];

endmodule

// File: rtl/hb_reg_writer.sv
module hb_reg_writer
  import hb_reg_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LEAD_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [15:0]       wr_data_i,
  output logic              busy_o,
  output logic              hb_cs_n_o,
  output logic              hb_ck_o,
  output logic [7:0]        hb_dq_o,
  output logic              hb_dq_oe_o,
  output logic              hb_rwds_o,
  output logic              hb_rwds_oe_o
);

  localparam int XFER_CYCLES = 2 * XFER_BYTES;
  localparam int CNT_W       = $clog2(XFER_CYCLES);
  localparam int IDX_W       = $clog2(XFER_BYTES);

  // Internal events, named for the checker.
  logic             accept_w;
  logic             in_xfer_w;
  logic             xfer_done_w;
  logic [CNT_W-1:0] cyc_w;
  logic [IDX_W-1:0] byte_idx_w;
  logic [7:0]       cur_byte_w;
  logic [8*XFER_BYTES-1:0] frame_w;

  assign frame_w = {ca_word(ADDR_FIELD'(wr_addr_i)), wr_data_i[7:0], wr_data_i[15:8]};

  hb_reg_ctrl #(
    .LEAD_CYCLES(LEAD_CYCLES),
    .XFER_CYCLES(XFER_CYCLES)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (wr_stb_i),
    .accept_o  (accept_w),
    .in_xfer_o (in_xfer_w),
    .busy_o    (busy_o),
    .done_o    (xfer_done_w),
    .cyc_o     (cyc_w)
  );

  assign byte_idx_w = cyc_w[CNT_W-1:1];

  hb_reg_frame #(
    .NBYTES(XFER_BYTES)
  ) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept_w),
    .frame_i (frame_w),
    .idx_i   (byte_idx_w),
    .byte_o  (cur_byte_w)
  );

  assign hb_cs_n_o    = !in_xfer_w;
  assign hb_ck_o      = in_xfer_w && bus_ck_level(8'(cyc_w));
  assign hb_dq_o      = in_xfer_w ? cur_byte_w : 8'h00;
  assign hb_dq_oe_o   = in_xfer_w;
  assign hb_rwds_o    = 1'b0;
  assign hb_rwds_oe_o = 1'b0;

endmodule

// File: rtl/hb_reg_writer_chk.sv
module hb_reg_writer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_stb_i,
  input logic       busy_o,
  input logic       hb_cs_n_o,
  input logic       hb_ck_o,
  input logic [7:0] hb_dq_o,
  input logic       hb_dq_oe_o,
  input logic       hb_rwds_o,
  input logic       hb_rwds_oe_o,
  input logic       accept_w,
  input logic       xfer_done_w
);

  p_start_delay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && !busy_o) |=> (hb_cs_n_o && busy_o) ##1 hb_cs_n_o ##1 !hb_cs_n_o);

  p_ck_idle_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_cs_n_o |-> !hb_ck_o);

  p_ck_low_at_cs_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hb_cs_n_o) |-> !hb_ck_o);

  p_oe_tracks_cs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_dq_oe_o == !hb_cs_n_o);

  p_rwds_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hb_rwds_o && !hb_rwds_oe_o);

  p_cs_within_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hb_cs_n_o |-> busy_o);

  p_busy_ignores_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !accept_w);

  p_release_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_w |=> (hb_cs_n_o && !busy_o && !hb_ck_o && hb_dq_o == 8'h00));

  p_dq_zero_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_cs_n_o |-> (hb_dq_o == 8'h00));

endmodule

bind hb_reg_writer hb_reg_writer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_stb_i     (wr_stb_i),
  .busy_o       (busy_o),
  .hb_cs_n_o    (hb_cs_n_o),
  .hb_ck_o      (hb_ck_o),
  .hb_dq_o      (hb_dq_o),
  .hb_dq_oe_o   (hb_dq_oe_o),
  .hb_rwds_o    (hb_rwds_o),
  .hb_rwds_oe_o (hb_rwds_oe_o),
  .accept_w     (accept_w),
  .xfer_done_w  (xfer_done_w)
);

// File: tb/hb_reg_writer_test.sv
module hb_reg_writer_test;

  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              stb = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       data = '0;
  logic              busy, cs_n, ck, dq_oe, rwds, rwds_oe;
  logic [7:0]        dq;

  int  errs = 0;
  int  checks = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  hb_reg_writer #(.ADDR_W(ADDR_W), .LEAD_CYCLES(2)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_stb_i     (stb),
    .wr_addr_i    (addr),
    .wr_data_i    (data),
    .busy_o       (busy),
    .hb_cs_n_o    (cs_n),
    .hb_ck_o      (ck),
    .hb_dq_o      (dq),
    .hb_dq_oe_o   (dq_oe),
    .hb_rwds_o    (rwds),
    .hb_rwds_oe_o (rwds_oe)
  );

  // Expected byte stream: header word then data low, data high.
  function automatic logic [63:0] exp_frame(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    logic [47:0] h;
    h = 48'h6000_0000_0000 | (48'(a) << 23);
    return {h, d[7:0], d[15:8]};
  endfunction

  function automatic logic [7:0] exp_byte(input logic [63:0] f, input int n);
    return 8'(f >> (8 * (7 - n)));
  endfunction

  // Bus clock: within the 16-cycle window, high for k = 1,2, 5,6, 9,10, 13,14.
  function automatic logic exp_ck(input int k);
    return (k % 4 == 1) || (k % 4 == 2);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, "cs_n", 64'(cs_n), 64'd1);
    check(req, "ck", 64'(ck), 64'd0);
    check(req, "dq", 64'(dq), 64'd0);
    check(req, "dq_oe", 64'(dq_oe), 64'd0);
    check(req, "busy", 64'(busy), 64'd0);
  endtask

  // Caller stands at a negedge. inj >= 0 places an ignored strobe at that cycle.
  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [15:0] d, input int inj);
    logic [63:0] f;
    f = exp_frame(a, d);
    stb = 1'b1; addr = a; data = d;
    for (int j = 0; j <= 18; j++) begin
      @(negedge clk);
      if (j >= 2 && j <= 17) begin
        int k;
        int n;
        k = j - 2;
        n = k / 2;
        check("R2", "cs_n low", 64'(cs_n), 64'd0);
        check("R6", "bus clock", 64'(ck), 64'(exp_ck(k)));
        if (n < 6)           check("R3", "header byte", 64'(dq), 64'(exp_byte(f, n)));
        else if (k % 2 == 0) check("R4", "data byte", 64'(dq), 64'(exp_byte(f, n)));
        else                 check("R5", "held data byte", 64'(dq), 64'(exp_byte(f, n)));
        check("R7", "dq_oe", 64'(dq_oe), 64'd1);
        check("R9", "busy in xfer", 64'(busy), 64'd1);
      end else if (j < 2) begin
        check("R2", "cs_n before lead end", 64'(cs_n), 64'd1);
        check("R9", "busy in lead", 64'(busy), 64'd1);
        check("R7", "dq_oe in lead", 64'(dq_oe), 64'd0);
      end else begin
        check_idle("R10");
      end
      check("R8", "rwds", 64'({rwds, rwds_oe}), 64'd0);
      stb = (j == inj);
      if (j == inj) begin
        addr = ADDR_W'($urandom);
        data = 16'($urandom);
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check_idle("R1");
    check("R1", "rwds", 64'({rwds, rwds_oe}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    // Directed: the reference pattern for address 2.
    do_write(8'd2, 16'h1234, -1);
    // Address field extremes.
    do_write(8'd0, 16'h0000, -1);
    do_write(8'hFF, 16'hFFFF, -1);
    // Ignored strobes in lead, in header, in data, on the last busy cycle.
    do_write(8'hA5, 16'hBEEF, 0);
    do_write(8'h3C, 16'h0F0F, 4);
    do_write(8'h81, 16'h8001, 15);
    do_write(8'h42, 16'h5AA5, 17);
    // Idle gap, pins must hold.
    repeat (5) begin
      @(negedge clk);
      check_idle("R10");
    end

    // Random mix with back-to-back and gapped requests.
    for (int t = 0; t < 40; t++) begin
      int inj;
      int gap;
      inj = ($urandom % 3 == 0) ? int'($urandom % 18) : -1;
      gap = int'($urandom % 3);
      do_write(ADDR_W'($urandom), 16'($urandom), inj);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        check_idle("R10");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule